// File: doc/BRIEF.md
# Converter Serial Output Port

This block is the digital output port of a 20-bit converter. The conversion core hands it a parallel result word together with a one-cycle load strobe. The port holds that word in an output register and shifts it out on a single data pin, most significant bit first, while the receiver holds chip select low. An active-low data-ready flag tells the receiver when a fresh, valid word is waiting.

A static mode input selects the serial clock source. With the mode input low, an external master drives the serial clock. The port synchronizes that clock to its master clock and moves to the next bit after each falling edge, so the receiver samples on rising edges. With the mode input high, the port makes its own serial clock. That clock runs at one quarter of the master clock and is high for one master cycle in every four.

A word that arrives while a transfer runs is parked and takes effect only after the current word has gone out. Every load makes data-ready go high for four master cycles. Holding the calibration input high for long enough clears the port.

Top module: `ser_out_port`

## Requirements
- R1: A word is sent as 20 bits on `sdata`, most significant bit first, with one bit per serial clock period.
- R2: With `mode_self` = 0, the MSB is on `sdata` when the transfer starts. Each later bit appears after a synchronized falling edge of `sclk_in`. `sdata` does not change between falling edges. The 20th falling edge ends the word.
- R3: With `mode_self` = 1, `sclk_out` rises every 4 master cycles during a transfer and is high for exactly one cycle of each period. Each word gets 20 pulses, and `sdata` is stable while `sclk_out` is high.
- R4: A transfer starts only when `cs_n` is low, a valid word is held and the data-ready invalid window has expired.
- R5: `drdy_n` is 1 after reset and whenever no valid word is held. It goes low when a loaded word becomes valid. It returns to 1 once all 20 bits of that word have been sent, unless a deferred word replaces it.
- R6: Each `load` pulse drives `drdy_n` high for exactly 4 master cycles after the loading edge. This happens whether or not a transfer is in progress.
- R7: A `load` during a transfer leaves the word being sent unchanged. The new word becomes the output word when the current transfer completes, and it is then sent in full.
- R8: Raising `cs_n` before the 20th bit aborts the transfer and keeps the word valid (`drdy_n` stays 0). The next transfer restarts at that word's MSB.
- R9: Holding `cal` high for 5 or more consecutive cycles clears the held word, any deferred word and any transfer, so `drdy_n` = 1. A pulse of 4 cycles or fewer has no effect. Loads are accepted again once `cal` is low.
- R10: `sdata` and `sclk_out` stay 0 while `cs_n` is high or no valid word is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_self | input | 1 | 0: external serial clock on `sclk_in`; 1: port drives `sclk_out` |
| cal | input | 1 | Calibration strobe; 5 or more cycles high clears the port |
| cs_n | input | 1 | Active-low chip select from the receiver |
| load | input | 1 | One-cycle strobe: `din` holds a new result |
| din | input | 20 | Parallel result word from the conversion core |
| sclk_in | input | 1 | External serial clock (mode_self = 0) |
| sclk_out | output | 1 | Generated serial clock (mode_self = 1) |
| sdata | output | 1 | Serial data, MSB first |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
A bit index that drifts shows up within one word as a wrong or shifted 20-bit value on `sdata`. If it never reaches the last bit, the word is never released and `drdy_n` stays low after the last serial clock. A phase counter that is off shows up inside the first pulse gap as a spacing other than four cycles. A deferred load that overwrites the live register corrupts the word still in flight. A wrong invalid-window count is visible on `drdy_n` within a few cycles of the load. A calibration counter that is off by one either clears the port on a 4-cycle pulse or misses a 5-cycle one. Either way, `drdy_n` shows the error two cycles after `cal` falls.

// File: rtl/ser_out_pkg.sv
// Shared definitions for the converter serial output port.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ser_out_pkg;

    // Serial clock source selected by the mode pin.
    typedef enum logic {
        CLK_EXTERNAL = 1'b0,
        CLK_INTERNAL = 1'b1
    } clk_src_e;

endpackage

// File: rtl/sclk_sync.sv
// Synchronizer and falling-edge detector for the external serial clock.
// Assumes: sclk_in is asynchronous to clk and slower than clk / 4.
module sclk_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Resynchronize the pin through a flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= sclk_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign fall = last_q && !sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/sclk_gen.sv
// Self-generated serial clock: one pulse of one master cycle every CLK_DIV cycles.
// Assumes: run is held for the whole transfer; phase restarts at 0 when run rises.
module sclk_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick,
    output logic sclk
);
    localparam int PH_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(CLK_DIV / 2);

    logic [PH_W-1:0] ph_q;

    // Phase counter that free-runs only while a transfer is active.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)     ph_q <= '0;
        else if (ph_q == PH_LAST) ph_q <= '0;
        else                    ph_q <= ph_q + 1'b1;
    end

    assign sclk = run && (ph_q == PH_HIGH);
    assign tick = run && (ph_q == PH_LAST);

    AST_SCLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk);  // R3

    AST_TICK_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !sclk);  // R3

endmodule

// File: rtl/drdy_timer.sv
// Counts the data-ready invalid window that follows each load.
// Assumes: start is a single-cycle strobe; a new start restarts the window.
module drdy_timer #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic busy
);
    localparam int W = $clog2(SETTLE_CYC + 1);

    logic [W-1:0] cnt_q;

    // Load the window length on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  cnt_q <= '0;
        else if (start)       cnt_q <= W'(SETTLE_CYC);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear) |=> busy);  // R6

endmodule

// File: rtl/ser_out_port.sv
// Serial output port of a converter: holds a result word, shifts it out MSB
// first under an external or self-generated serial clock, and drives an
// active-low data-ready flag. Loads during a transfer are deferred.
// Assumes: mode_self is static during a transfer; load is a one-cycle strobe.
module ser_out_port
    import ser_out_pkg::*;
#(
    parameter int WORD_W      = 20,
    parameter int SETTLE_CYC  = 4,
    parameter int CAL_CYC     = 4,
    parameter int CLK_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_self,
    input  logic              cal,
    input  logic              cs_n,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sdata,
    output logic              drdy_n
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam int CAL_W = $clog2(CAL_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    clk_src_e          src;
    logic              self_mode;
    logic              ext_fall, self_tick, tick;
    logic              win_busy;
    logic [CAL_W-1:0]  cal_cnt;
    logic              cal_rst;
    logic              active, valid, pend;
    logic [CNT_W-1:0]  bit_idx;
    logic [WORD_W-1:0] word_q, pend_q;
    logic              start_ok;

    assign src       = clk_src_e'(mode_self);
    assign self_mode = (src == CLK_INTERNAL);

    // Count consecutive cycles of cal high, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !cal) cal_cnt <= '0;
        else if (!cal_rst)  cal_cnt <= cal_cnt + 1'b1;
    end

    assign cal_rst = cal && (cal_cnt >= CAL_W'(CAL_CYC));

    sclk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk_in),
        .fall    (ext_fall)
    );

    sclk_gen #(.CLK_DIV(CLK_DIV)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active && self_mode),
        .tick  (self_tick),
        .sclk  (sclk_out)
    );

    drdy_timer #(.SETTLE_CYC(SETTLE_CYC)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cal_rst),
        .start (load && !cal_rst),
        .busy  (win_busy)
    );

    assign tick     = active && (self_mode ? self_tick : ext_fall);
    assign start_ok = !cs_n && valid && !win_busy;

    // Output register, deferred word and transfer sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || cal_rst) begin
            active  <= 1'b0;
            valid   <= 1'b0;
            pend    <= 1'b0;
            bit_idx <= '0;
            word_q  <= '0;
            pend_q  <= '0;
        end else if (active) begin
            if (cs_n) begin
                active  <= 1'b0;
                bit_idx <= '0;
            end else if (tick) begin
                if (bit_idx == LAST_BIT) begin
                    active  <= 1'b0;
                    bit_idx <= '0;
                    if (pend) begin
                        word_q <= pend_q;
                        pend   <= 1'b0;
                    end else begin
                        valid  <= 1'b0;
                    end
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
            if (load) begin
                pend_q <= din;
                pend   <= 1'b1;
            end
        end else begin
            if (load) begin
                word_q <= din;
                valid  <= 1'b1;
                pend   <= 1'b0;
            end else if (pend) begin
                word_q <= pend_q;
                valid  <= 1'b1;
                pend   <= 1'b0;
            end else if (start_ok) begin
                active <= 1'b1;
            end
        end
    end

    assign sdata  = active && word_q[LAST_BIT - bit_idx];
    assign drdy_n = !valid || win_busy;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> (!sdata && !sclk_out));  // R10

    AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !cal_rst) |=> drdy_n);  // R6

    AST_CAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cal_rst |=> (drdy_n && !sdata && !sclk_out));  // R9

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !self_mode && !ext_fall && !cs_n && !cal && !load) |=> $stable(sdata));  // R2

    AST_DEFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && load && !tick && !cs_n && !cal) |=> $stable(word_q));  // R7

    AST_NO_START_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !valid) |=> !sclk_out);  // R4

endmodule

// File: tb/ser_out_port_test.sv
// Scoreboard bench: the driver pushes expected words, the monitor rebuilds
// words from sdata at each serial clock rising edge and compares them.
module ser_out_port_test;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_self = 1'b1;
    logic         cal = 1'b0;
    logic         cs_n = 1'b1;
    logic         load = 1'b0;
    logic [W-1:0] din = '0;
    logic         sclk_in = 1'b0;
    logic         sclk_out, sdata, drdy_n;

    int checks = 0;
    int errors = 0;
    int words_done = 0;
    logic [W-1:0] exp_q[$];

    ser_out_port uut (
        .clk(clk), .rst_n(rst_n), .mode_self(mode_self), .cal(cal),
        .cs_n(cs_n), .load(load), .din(din), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sdata(sdata), .drdy_n(drdy_n)
    );

    always #10 clk = ~clk;  // 50 MHz

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fin();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Move to a point safely after the falling edge before driving.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
        end
        #2;
    endtask

    task automatic do_load(input logic [W-1:0] w);
        step(1); din = w; load = 1'b1;
        step(1); load = 1'b0;
    endtask

    // Count the cycles drdy_n stays high after a load edge.
    task automatic measure_window(input string req);
        int n = 0;
        while (drdy_n === 1'b1 && n < 50) begin
            n++;
            @(negedge clk);
        end
        chk(n == 4, req, n, 4);
    endtask

    task automatic ext_bits(input int n);
        for (int i = 0; i < n; i++) begin
            sclk_in = 1'b1; step(8);
            sclk_in = 1'b0; step(8);
        end
    endtask

    // Monitor: capture a bit on each serial clock rise and score full words.
    logic [W-1:0] cap = '0;
    int ncap = 0;
    int gap = 0;
    logic sc_prev = 1'b0;
    always @(negedge clk) begin
        logic sc;
        logic [W-1:0] e;
        sc = mode_self ? sclk_out : sclk_in;
        if (!rst_n || cs_n) begin
            ncap = 0;
            gap = 0;
        end else begin
            gap++;
            if (sc && !sc_prev) begin
                if (mode_self && ncap > 0) chk(gap == 4, "R3 pulse spacing", gap, 4);
                gap = 0;
                cap = {cap[W-2:0], sdata};
                ncap++;
                if (ncap == W) begin
                    ncap = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R1 unexpected word", int'(cap), 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(cap == e, "R1 word", int'(cap), int'(e));
                    end
                    words_done++;
                end
            end
        end
        sc_prev = sc;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        fin();
    end

    initial begin
        int hi;
        int base;
        step(5);
        rst_n = 1'b1;
        step(1);
        chk(drdy_n == 1'b1, "R5 reset drdy_n", drdy_n, 1);
        chk(sdata == 1'b0, "R10 reset sdata", sdata, 0);
        chk(sclk_out == 1'b0, "R10 reset sclk_out", sclk_out, 0);

        // No valid word: chip select alone must not start anything.
        cs_n = 1'b0;
        hi = 0;
        for (int i = 0; i < 12; i++) begin
            step(1);
            if (sclk_out || sdata) hi++;
        end
        chk(hi == 0, "R4 no start without word", hi, 0);
        cs_n = 1'b1;

        // Load and invalid window.
        do_load(20'hA5C3E);
        measure_window("R6 window after idle load");
        chk(drdy_n == 1'b0, "R5 drdy low after load", drdy_n, 0);
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            step(1);
            if (sclk_out || sdata) hi++;
        end
        chk(hi == 0, "R10 quiet while cs_n high", hi, 0);

        // Self-clocked transfer.
        exp_q.push_back(20'hA5C3E);
        base = words_done;
        cs_n = 1'b0;
        wait (words_done == base + 1);
        step(2);
        chk(drdy_n == 1'b1, "R5 drdy high after word", drdy_n, 1);
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            step(1);
            if (sclk_out) hi++;
        end
        chk(hi == 0, "R3 no pulses once word is sent", hi, 0);
        cs_n = 1'b1;

        // External clock, aborted then restarted.
        step(2);
        mode_self = 1'b0;
        do_load(20'h3C5A1);
        step(6);
        exp_q.push_back(20'h3C5A1);
        cs_n = 1'b0;
        step(4);
        chk(sdata == 1'b0, "R2 MSB present at start", sdata, 0);
        ext_bits(7);
        cs_n = 1'b1;
        step(3);
        chk(sdata == 1'b0, "R8 sdata low after abort", sdata, 0);
        chk(drdy_n == 1'b0, "R8 word still valid", drdy_n, 0);
        chk(exp_q.size() == 1, "R8 no word scored on abort", exp_q.size(), 1);
        base = words_done;
        cs_n = 1'b0;
        step(4);
        ext_bits(20);
        step(6);
        chk(words_done == base + 1, "R2 word ends at 20th fall", words_done - base, 1);
        chk(drdy_n == 1'b1, "R2 released after 20 falls", drdy_n, 1);
        cs_n = 1'b1;

        // Deferred load during a self-clocked transfer.
        step(2);
        mode_self = 1'b1;
        do_load(20'hF0F0F);
        step(6);
        exp_q.push_back(20'hF0F0F);
        exp_q.push_back(20'h12345);
        base = words_done;
        cs_n = 1'b0;
        step(30);
        din = 20'h12345; load = 1'b1;
        step(1); load = 1'b0;
        measure_window("R6 window during transfer");
        chk(drdy_n == 1'b0, "R7 current word still valid", drdy_n, 0);
        wait (words_done == base + 1);
        step(1);
        chk(drdy_n == 1'b0, "R7 deferred word now valid", drdy_n, 0);
        wait (words_done == base + 2);
        step(2);
        chk(drdy_n == 1'b1, "R5 drdy high after deferred word", drdy_n, 1);
        cs_n = 1'b1;

        // Short calibration pulse has no effect.
        do_load(20'h0F00F);
        step(6);
        cal = 1'b1; step(4); cal = 1'b0;
        step(2);
        chk(drdy_n == 1'b0, "R9 short cal ignored", drdy_n, 0);
        exp_q.push_back(20'h0F00F);
        base = words_done;
        cs_n = 1'b0;
        wait (words_done == base + 1);
        step(2);
        cs_n = 1'b1;

        // Long calibration pulse clears the port.
        do_load(20'h8BEEF);
        step(6);
        cal = 1'b1; step(6); cal = 1'b0;
        step(2);
        chk(drdy_n == 1'b1, "R9 long cal clears word", drdy_n, 1);
        cs_n = 1'b0;
        hi = 0;
        for (int i = 0; i < 16; i++) begin
            step(1);
            if (sclk_out || sdata) hi++;
        end
        chk(hi == 0, "R9 nothing sent after cal", hi, 0);
        cs_n = 1'b1;

        // Resume after calibration.
        do_load(20'h6D2B7);
        step(6);
        exp_q.push_back(20'h6D2B7);
        base = words_done;
        cs_n = 1'b0;
        wait (words_done == base + 1);
        step(2);
        cs_n = 1'b1;
        step(4);
        chk(exp_q.size() == 0, "R1 all expected words seen", exp_q.size(), 0);
        fin();
    end
endmodule